// File: doc/BRIEF.md
# Tag-Snooping Reservation Station

This block is a small pool of waiting slots that sits in front of one execution unit of a speculative out-of-order core. When an instruction is accepted, a slot takes its operation code, its two source operands and the reorder-buffer index that will hold its result. Each source arrives in one of two forms. It is either a finished value, or the reorder-buffer index of the older instruction that will produce that value.

Slots watch a single broadcast result bus. When the bus carries the index of a producer that a slot is waiting on, the slot copies the broadcast value into that operand. Once both operands of a slot hold values, the slot can be started on the execution unit. When several slots can start, the slot whose instruction is oldest relative to the reorder-buffer head goes first, and at most one slot starts per cycle. A slot stays occupied after it starts. It is released only when the bus broadcasts the slot's own destination index.

On a mispredicted branch, every slot whose destination index is younger than the branch is discarded.

Top module: `rs_station`

## Requirements
- R1: `iss_ready` is high exactly when at least one slot is free, `rob_free` is high and `flush_valid` is low. An instruction is accepted only on a cycle where both `iss_valid` and `iss_ready` are high. An instruction presented while `iss_ready` is low leaves no trace.
- R2: Each source operand is accepted either as a value (`iss_x_rdy`=1, value on `iss_x_val`) or as a producer index (`iss_x_rdy`=0, index on `iss_x_tag`). When the slot starts, source A appears on `ex_a` and source B on `ex_b`.
- R3: A started slot presents its operation code on `ex_op` and its destination reorder-buffer index on `ex_dst`.
- R4: While a slot waits on a producer index, a bus cycle with `cdb_valid`=1 and `cdb_tag` equal to that index stores `cdb_value` into the operand.
- R5: A slot is started (`ex_valid`=1 one cycle after it becomes eligible) only when both of its operands hold values. A slot with a missing operand never starts.
- R6: A slot that has started is freed by a bus cycle whose `cdb_tag` equals its destination index. Before that broadcast it stays occupied, even after starting.
- R7: If the bus broadcasts a producer index in the same cycle as the instruction that needs it is accepted, the operand takes the broadcast value at acceptance.
- R8: At most one slot starts per cycle. Among eligible slots, the one with the smallest value of (destination − `rob_head`) modulo 2^TAG_W starts first.
- R9: While `flush_valid` is high, every slot whose (destination − `rob_head`) is larger than (`flush_tag` − `rob_head`), both modulo 2^TAG_W, is discarded and never starts. Slots with a smaller or equal value are kept.
- R10: After reset all slots are free and `ex_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Instruction offered for acceptance |
| iss_op | input | OP_W | Operation code |
| iss_dst | input | TAG_W | Destination reorder-buffer index |
| iss_a_rdy | input | 1 | Source A is a value (1) or a producer index (0) |
| iss_a_val | input | DATA_W | Source A value |
| iss_a_tag | input | TAG_W | Source A producer index |
| iss_b_rdy | input | 1 | Source B is a value (1) or a producer index (0) |
| iss_b_val | input | DATA_W | Source B value |
| iss_b_tag | input | TAG_W | Source B producer index |
| rob_free | input | 1 | Reorder buffer has a free slot |
| iss_ready | output | 1 | Acceptance possible this cycle |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TAG_W | Index of the broadcast result |
| cdb_value | input | DATA_W | Broadcast result value |
| rob_head | input | TAG_W | Index of the oldest reorder-buffer entry |
| flush_valid | input | 1 | Mispredict recovery request |
| flush_tag | input | TAG_W | Index of the mispredicted branch |
| ex_valid | output | 1 | A slot starts on the execution unit |
| ex_op | output | OP_W | Operation code of the started slot |
| ex_a | output | DATA_W | Source A value |
| ex_b | output | DATA_W | Source B value |
| ex_dst | output | TAG_W | Destination index of the started slot |

## Verification
Two pairs of functions can meet in one cycle. The first is acceptance of an instruction while the bus broadcasts the very index that instruction is waiting on. The bench drives both on one edge and then requires the broadcast value on `ex_a` one cycle later, which shows the wakeup was not lost. The second is a flush arriving while older and younger slots are pending. The bench checks that `iss_ready` drops during the flush, that the older slots still start in age order, and that the younger slot never appears on `ex_dst`.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Distance of a reorder-buffer index from the head, modulo 2^bits.
  function automatic logic [31:0] rel_age(input logic [31:0] tag,
                                          input logic [31:0] head,
                                          input int unsigned bits);
    logic [31:0] mask;
    mask = (32'd1 << bits) - 32'd1;
    return (tag - head) & mask;
  endfunction

endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int ENTRIES = 4
) (
  input  logic [ENTRIES-1:0] busy,
  output logic [ENTRIES-1:0] pick,
  output logic               any_free
);
  always_comb begin
    pick = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
    any_free = ~&busy;
  end
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 3
) (
  input  logic [ENTRIES-1:0]       elig,
  input  logic [ENTRIES*TAG_W-1:0] dst_flat,
  input  logic [TAG_W-1:0]         head,
  output logic [ENTRIES-1:0]       take,
  output logic                     any
);
  import rs_pkg::*;

  always_comb begin
    logic [31:0] best;
    logic [31:0] cur;
    take = '0;
    any  = 1'b0;
    best = '1;
    for (int i = 0; i < ENTRIES; i++) begin
      cur = rel_age(32'(dst_flat[i*TAG_W +: TAG_W]), 32'(head), TAG_W);
      if (elig[i] && (!any || cur < best)) begin
        take    = '0;
        take[i] = 1'b1;
        best    = cur;
        any     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   in_op,
  input  logic [TAG_W-1:0]  in_dst,
  input  logic              in_a_rdy,
  input  logic [DATA_W-1:0] in_a_val,
  input  logic [TAG_W-1:0]  in_a_tag,
  input  logic              in_b_rdy,
  input  logic [DATA_W-1:0] in_b_val,
  input  logic [TAG_W-1:0]  in_b_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              kill,
  input  logic              take,
  output logic              valid,
  output logic              sent,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dst,
  output logic              a_rdy,
  output logic [DATA_W-1:0] a_val,
  output logic              b_rdy,
  output logic [DATA_W-1:0] b_val
);
  logic [TAG_W-1:0] a_tag;
  logic [TAG_W-1:0] b_tag;

  wire in_a_hit = cdb_valid && (cdb_tag == in_a_tag);
  wire in_b_hit = cdb_valid && (cdb_tag == in_b_tag);
  wire a_hit    = cdb_valid && (cdb_tag == a_tag);
  wire b_hit    = cdb_valid && (cdb_tag == b_tag);
  wire own_hit  = cdb_valid && (cdb_tag == dst);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      sent  <= 1'b0;
      a_rdy <= 1'b0;
      b_rdy <= 1'b0;
    end else if (alloc) begin
      valid <= 1'b1;
      sent  <= 1'b0;
      op    <= in_op;
      dst   <= in_dst;
      a_tag <= in_a_tag;
      b_tag <= in_b_tag;
      if (in_a_rdy) begin
        a_rdy <= 1'b1;
        a_val <= in_a_val;
      end else if (in_a_hit) begin
        a_rdy <= 1'b1;
        a_val <= cdb_value;
      end else begin
        a_rdy <= 1'b0;
      end
      if (in_b_rdy) begin
        b_rdy <= 1'b1;
        b_val <= in_b_val;
      end else if (in_b_hit) begin
        b_rdy <= 1'b1;
        b_val <= cdb_value;
      end else begin
        b_rdy <= 1'b0;
      end
    end else if (valid) begin
      if (kill) begin
        valid <= 1'b0;
      end else if (sent && own_hit) begin
        valid <= 1'b0;
      end else begin
        if (take) sent <= 1'b1;
        if (!a_rdy && a_hit) begin
          a_rdy <= 1'b1;
          a_val <= cdb_value;
        end
        if (!b_rdy && b_hit) begin
          b_rdy <= 1'b1;
          b_val <= cdb_value;
        end
      end
    end
  end
endmodule

// File: rtl/rs_station.sv
module rs_station #(
  parameter int ENTRIES = 4,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 3,
  parameter int OP_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              iss_a_rdy,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic              iss_b_rdy,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic              rob_free,
  output logic              iss_ready,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic [TAG_W-1:0]  rob_head,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag,
  output logic              ex_valid,
  output logic [OP_W-1:0]   ex_op,
  output logic [DATA_W-1:0] ex_a,
  output logic [DATA_W-1:0] ex_b,
  output logic [TAG_W-1:0]  ex_dst
);
  import rs_pkg::*;

  localparam int DST_BITS = ENTRIES * TAG_W;

  logic [ENTRIES-1:0]  ent_valid, ent_sent, ent_ardy, ent_brdy;
  logic [ENTRIES-1:0]  alloc_pick, alloc_vec, kill_vec, elig_vec, take_vec;
  logic [DST_BITS-1:0] ent_dst_flat;
  logic                any_free, any_take, accept;

  logic [OP_W-1:0]   e_op  [ENTRIES];
  logic [TAG_W-1:0]  e_dst [ENTRIES];
  logic [DATA_W-1:0] e_a   [ENTRIES];
  logic [DATA_W-1:0] e_b   [ENTRIES];

  rs_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .busy(ent_valid), .pick(alloc_pick), .any_free(any_free)
  );

  assign iss_ready = any_free && rob_free && !flush_valid;
  assign accept    = iss_valid && iss_ready;
  assign alloc_vec = accept ? alloc_pick : '0;

  logic [31:0] flush_age;
  assign flush_age = rel_age(32'(flush_tag), 32'(rob_head), TAG_W);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    rs_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) u_ent (
      .clk(clk), .rst(rst), .alloc(alloc_vec[g]),
      .in_op(iss_op), .in_dst(iss_dst),
      .in_a_rdy(iss_a_rdy), .in_a_val(iss_a_val), .in_a_tag(iss_a_tag),
      .in_b_rdy(iss_b_rdy), .in_b_val(iss_b_val), .in_b_tag(iss_b_tag),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
      .kill(kill_vec[g]), .take(take_vec[g]),
      .valid(ent_valid[g]), .sent(ent_sent[g]),
      .op(e_op[g]), .dst(e_dst[g]),
      .a_rdy(ent_ardy[g]), .a_val(e_a[g]),
      .b_rdy(ent_brdy[g]), .b_val(e_b[g])
    );
    assign ent_dst_flat[g*TAG_W +: TAG_W] = e_dst[g];
    assign kill_vec[g] = flush_valid &&
                         (rel_age(32'(e_dst[g]), 32'(rob_head), TAG_W) > flush_age);
    assign elig_vec[g] = ent_valid[g] && !ent_sent[g] && ent_ardy[g] &&
                         ent_brdy[g] && !kill_vec[g];
  end

  rs_select #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_sel (
    .elig(elig_vec), .dst_flat(ent_dst_flat), .head(rob_head),
    .take(take_vec), .any(any_take)
  );

  logic [OP_W-1:0]   m_op;
  logic [DATA_W-1:0] m_a, m_b;
  logic [TAG_W-1:0]  m_dst;

  always_comb begin
    m_op = '0; m_a = '0; m_b = '0; m_dst = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (take_vec[i]) begin
        m_op  = m_op  | e_op[i];
        m_a   = m_a   | e_a[i];
        m_b   = m_b   | e_b[i];
        m_dst = m_dst | e_dst[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid <= 1'b0;
      ex_op    <= '0;
      ex_a     <= '0;
      ex_b     <= '0;
      ex_dst   <= '0;
    end else begin
      ex_valid <= any_take;
      if (any_take) begin
        ex_op  <= m_op;
        ex_a   <= m_a;
        ex_b   <= m_b;
        ex_dst <= m_dst;
      end
    end
  end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     iss_ready,
  input logic                     flush_valid,
  input logic [TAG_W-1:0]         flush_tag,
  input logic [TAG_W-1:0]         rob_head,
  input logic [ENTRIES-1:0]       ent_valid,
  input logic [ENTRIES-1:0]       ent_sent,
  input logic [ENTRIES-1:0]       ent_ardy,
  input logic [ENTRIES-1:0]       ent_brdy,
  input logic [ENTRIES-1:0]       take_vec,
  input logic [ENTRIES*TAG_W-1:0] ent_dst_flat
);
  import rs_pkg::*;

  assert_full_blocks_issue_R1: assert property (@(posedge clk) disable iff (rst)
    ($countones(ent_valid) == ENTRIES) |-> !iss_ready);

  assert_single_start_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(take_vec));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    logic [31:0] d_age, f_age;
    assign d_age = rel_age(32'(ent_dst_flat[g*TAG_W +: TAG_W]), 32'(rob_head), TAG_W);
    assign f_age = rel_age(32'(flush_tag), 32'(rob_head), TAG_W);

    assert_start_needs_operands_R5: assert property (@(posedge clk) disable iff (rst)
      take_vec[g] |-> (ent_valid[g] && !ent_sent[g] && ent_ardy[g] && ent_brdy[g]));

    assert_held_until_started_R6: assert property (@(posedge clk) disable iff (rst)
      (ent_valid[g] && !ent_sent[g] && !flush_valid) |=> ent_valid[g]);

    assert_flush_drops_younger_R9: assert property (@(posedge clk) disable iff (rst)
      (flush_valid && ent_valid[g] && (d_age > f_age)) |=> !ent_valid[g]);
  end
endmodule

bind rs_station rs_station_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .iss_ready(iss_ready),
  .flush_valid(flush_valid), .flush_tag(flush_tag), .rob_head(rob_head),
  .ent_valid(ent_valid), .ent_sent(ent_sent), .ent_ardy(ent_ardy),
  .ent_brdy(ent_brdy), .take_vec(take_vec), .ent_dst_flat(ent_dst_flat)
);

// File: tb/tb_rs_station.sv
module tb_rs_station;
  localparam int ENTRIES = 4;
  localparam int DATA_W  = 16;
  localparam int TAG_W   = 3;
  localparam int OP_W    = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic iss_valid = 0, iss_a_rdy = 0, iss_b_rdy = 0, rob_free = 1;
  logic [OP_W-1:0] iss_op = '0;
  logic [TAG_W-1:0] iss_dst = '0, iss_a_tag = '0, iss_b_tag = '0;
  logic [DATA_W-1:0] iss_a_val = '0, iss_b_val = '0;
  logic cdb_valid = 0;
  logic [TAG_W-1:0] cdb_tag = '0, rob_head = '0, flush_tag = '0;
  logic [DATA_W-1:0] cdb_value = '0;
  logic flush_valid = 0;
  logic iss_ready, ex_valid;
  logic [OP_W-1:0] ex_op;
  logic [DATA_W-1:0] ex_a, ex_b;
  logic [TAG_W-1:0] ex_dst;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rs_station #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_a_rdy(iss_a_rdy), .iss_a_val(iss_a_val), .iss_a_tag(iss_a_tag),
    .iss_b_rdy(iss_b_rdy), .iss_b_val(iss_b_val), .iss_b_tag(iss_b_tag),
    .rob_free(rob_free), .iss_ready(iss_ready),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .rob_head(rob_head), .flush_valid(flush_valid), .flush_tag(flush_tag),
    .ex_valid(ex_valid), .ex_op(ex_op), .ex_a(ex_a), .ex_b(ex_b), .ex_dst(ex_dst)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Sets up an acceptance; caller decides on the edge.
  task automatic put(input int op, input int dst, input bit ar, input int av, input int at,
                     input bit br, input int bv, input int bt);
    iss_valid = 1; iss_op = OP_W'(op); iss_dst = TAG_W'(dst);
    iss_a_rdy = ar; iss_a_val = DATA_W'(av); iss_a_tag = TAG_W'(at);
    iss_b_rdy = br; iss_b_val = DATA_W'(bv); iss_b_tag = TAG_W'(bt);
  endtask

  task automatic issue(input int op, input int dst, input bit ar, input int av, input int at,
                       input bit br, input int bv, input int bt);
    put(op, dst, ar, av, at, br, bv, bt);
    step();
    iss_valid = 0;
  endtask

  task automatic bcast(input int tag, input int val);
    cdb_valid = 1; cdb_tag = TAG_W'(tag); cdb_value = DATA_W'(val);
    step();
    cdb_valid = 0;
  endtask

  task automatic t_reset();
    chk_eq("R10 ex_valid after reset", int'(ex_valid), 0);
    chk_eq("R10 iss_ready after reset", int'(iss_ready), 1);
  endtask

  task automatic t_ready_operands();
    issue(5, 1, 1, 'h1111, 0, 1, 'h2222, 0);
    step();
    chk_eq("R5 ex_valid", int'(ex_valid), 1);
    chk_eq("R2 ex_a", int'(ex_a), 'h1111);
    chk_eq("R2 ex_b", int'(ex_b), 'h2222);
    chk_eq("R3 ex_op", int'(ex_op), 5);
    chk_eq("R3 ex_dst", int'(ex_dst), 1);
    step();
    chk_eq("R8 single start", int'(ex_valid), 0);
    bcast(1, 'h0);
  endtask

  task automatic t_wakeup();
    issue(3, 2, 0, 0, 5, 1, 'h0BB0, 0);
    step();
    chk_eq("R5 waits on missing operand", int'(ex_valid), 0);
    bcast(5, 'hABCD);
    step();
    chk_eq("R4 start after capture", int'(ex_valid), 1);
    chk_eq("R4 captured value", int'(ex_a), 'hABCD);
    chk_eq("R2 value operand kept", int'(ex_b), 'h0BB0);
    bcast(2, 0);
  endtask

  task automatic t_same_cycle();
    put(7, 3, 0, 0, 6, 1, 'h0042, 0);
    cdb_valid = 1; cdb_tag = 3'd6; cdb_value = 16'h5555;
    step();
    iss_valid = 0; cdb_valid = 0;
    step();
    chk_eq("R7 start after same-cycle capture", int'(ex_valid), 1);
    chk_eq("R7 captured at acceptance", int'(ex_a), 'h5555);
    bcast(3, 0);
  endtask

  task automatic t_age_order(input int head, input int d_first_in, input int d_second_in,
                             input int old_dst, input int young_dst);
    rob_head = TAG_W'(head);
    issue(1, d_first_in, 1, 'h10, 0, 0, 0, 7);
    issue(2, d_second_in, 1, 'h20, 0, 0, 0, 7);
    bcast(7, 'h77);
    step();
    chk_eq("R8 oldest first", int'(ex_dst), old_dst);
    chk_eq("R8 first valid", int'(ex_valid), 1);
    step();
    chk_eq("R8 younger next", int'(ex_dst), young_dst);
    chk_eq("R8 second valid", int'(ex_valid), 1);
    bcast(old_dst, 0);
    bcast(young_dst, 0);
    rob_head = '0;
  endtask

  task automatic t_full_and_free();
    for (int i = 0; i < ENTRIES; i++) issue(1, i, 0, 0, 6, 1, 0, 0);
    chk_eq("R1 full blocks acceptance", int'(iss_ready), 0);
    issue(9, 5, 1, 'h99, 0, 1, 'h99, 0);
    chk_eq("R1 blocked issue ignored", int'(ex_valid), 0);
    bcast(6, 'h66);
    for (int i = 0; i < ENTRIES; i++) begin
      step();
      chk_eq("R8 drain order", int'(ex_dst), i);
    end
    step();
    chk_eq("R1 blocked issue never starts", int'(ex_valid), 0);
    chk_eq("R6 started slots stay held", int'(iss_ready), 0);
    bcast(0, 0);
    chk_eq("R6 freed by own broadcast", int'(iss_ready), 1);
    rob_free = 0;
    #1;
    chk_eq("R1 no reorder slot", int'(iss_ready), 0);
    rob_free = 1;
    for (int i = 1; i < ENTRIES; i++) bcast(i, 0);
  endtask

  task automatic t_flush();
    issue(1, 1, 0, 0, 7, 1, 0, 0);
    issue(1, 3, 0, 0, 7, 1, 0, 0);
    issue(1, 5, 0, 0, 7, 1, 0, 0);
    flush_valid = 1; flush_tag = 3'd3;
    #1;
    chk_eq("R1 no acceptance during flush", int'(iss_ready), 0);
    step();
    flush_valid = 0;
    bcast(7, 'h7);
    step();
    chk_eq("R9 older kept", int'(ex_dst), 1);
    step();
    chk_eq("R9 branch-age kept", int'(ex_dst), 3);
    chk_eq("R9 valid", int'(ex_valid), 1);
    step();
    chk_eq("R9 younger discarded", int'(ex_valid), 0);
    bcast(1, 0);
    bcast(3, 0);
    chk_eq("R9 slots back", int'(iss_ready), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    step();
    t_reset();
    t_ready_operands();
    t_wakeup();
    t_same_cycle();
    t_age_order(0, 4, 2, 2, 4);
    t_age_order(3, 1, 5, 5, 1);
    t_full_and_free();
    t_flush();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule